// File: doc/BRIEF.md
# Directory Home Controller

This block is the home node for one slice of memory lines in a multiprocessor whose caches share no snooping bus. It keeps one directory entry per line. Each entry holds a line state and a presence vector with one bit per cache. The block also holds the backing data for its lines. Requester nodes send it read, ownership (write) and write-back messages. The block answers each one on a reply channel. When other caches must be told, it sends point-to-point probes only to the caches recorded in the entry. It counts their acknowledgements and only then finishes the transaction.

Only one probing transaction is open at a time. A read or an ownership request that needs no probes is answered one cycle after it is presented. A request that needs probes marks the controller busy. The probes then leave one per cycle, and the reply follows once every acknowledgement has arrived. While the controller is busy, every newly arriving request gets a retry answer and is otherwise dropped.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every line is uncached with no holders, and its data equals (line*257) XOR 0x5A5A, truncated to the data width. No reply and no probe is valid while the first request is outstanding.
- R2: A read (req_kind 0) of an uncached or shared line sends no probe. One cycle after the request it replies with rsp_kind 0 (data) carrying the stored data. The line becomes shared with the requester added to its holders.
- R3: A read of a dirty line sends one fetch probe (prb_kind 1) to the owner. After the owner answers with cresp_kind 1 and its data, the reply carries that data and the stored data takes it. The line becomes shared with both owner and requester as holders.
- R4: An ownership request (req_kind 1) sends one invalidate probe (prb_kind 0) to each recorded holder other than the requester. The probes go one per cycle in ascending node order, and none goes to the requester.
- R5: An ownership request that sent probes replies with rsp_kind 1 (grant) only after as many acknowledgements (cresp_kind 0) as probes sent. The line is then dirty with the requester as its only holder.
- R6: An ownership request with no other holder is granted one cycle later, with no probe, carrying the stored data.
- R7: When an ownership request invalidates a dirty owner, the data in the owner's acknowledgement becomes both the stored data and the grant data.
- R8: While a transaction is open, any new request is answered one cycle later with rsp_kind 2 (retry), addressed to its sender. It has no other effect.
- R9: A write-back (req_kind 2) from the sole owner of a dirty line replies rsp_kind 3 and stores its data. The line becomes uncached, so a later read is served from memory with no probe.
- R10: A write-back from a node that does not own the line dirty replies rsp_kind 3 and changes neither the entry nor the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request message present this cycle |
| req_kind | input | 2 | 0 read, 1 ownership, 2 write-back |
| req_src | input | NID_W | Requesting node |
| req_line | input | LINE_W | Line index within this home slice |
| req_data | input | DATA_W | Write-back data |
| cresp_valid | input | 1 | Cache answer to a probe present this cycle |
| cresp_kind | input | 1 | 0 invalidate acknowledgement, 1 fetched data |
| cresp_src | input | NID_W | Answering node |
| cresp_line | input | LINE_W | Line the answer refers to |
| cresp_data | input | DATA_W | Line data carried by the answer |
| rsp_valid | output | 1 | Reply message valid |
| rsp_kind | output | 2 | 0 data, 1 grant, 2 retry, 3 write-back done |
| rsp_dst | output | NID_W | Node the reply is for |
| rsp_line | output | LINE_W | Line of the reply |
| rsp_data | output | DATA_W | Line data for data and grant replies |
| prb_valid | output | 1 | Probe message valid |
| prb_kind | output | 1 | 0 invalidate, 1 fetch |
| prb_dst | output | NID_W | Node being probed |
| prb_line | output | LINE_W | Line being probed |

## Verification
The assertions take for granted that caches answer only probes they have received, once each, naming the probed line and their own node. Under that assumption acknowledgements never outnumber probes, and a finishing transaction is balanced. The stimulus acts as every cache at once: each probe gets its answer in the cycle it is seen, carrying the data the bench holds for the current owner. A request is never presented in the cycle the reply of the previous one appears, except for the deliberate retry case. That intruder arrives only while probes are outstanding.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {
    ST_UNC   = 2'd0,
    ST_SHR   = 2'd1,
    ST_DIRTY = 2'd2
  } dstate_e;

  typedef enum logic [1:0] {
    REQ_READ  = 2'd0,
    REQ_WRITE = 2'd1,
    REQ_WB    = 2'd2
  } req_e;

  typedef enum logic [1:0] {
    RSP_DATA  = 2'd0,
    RSP_GRANT = 2'd1,
    RSP_NACK  = 2'd2,
    RSP_WBACK = 2'd3
  } rsp_e;

  typedef enum logic {
    PRB_INV   = 1'b0,
    PRB_FETCH = 1'b1
  } prb_e;

  typedef enum logic {
    ACK_INV  = 1'b0,
    ACK_DATA = 1'b1
  } ack_e;

  // Reset content of a memory line.
  function automatic logic [31:0] mem_seed(input int unsigned idx);
    return (idx * 32'd257) ^ 32'h0000_5A5A;
  endfunction

endpackage

// File: rtl/dir_table.sv
module dir_table
  import dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int LINES  = 8,
  parameter int DATA_W = 16,
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line,
  output dstate_e           rd_state,
  output logic [NODES-1:0]  rd_pres,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ent_we,
  input  dstate_e           wr_state,
  input  logic [NODES-1:0]  wr_pres,
  input  logic              mem_we,
  input  logic [DATA_W-1:0] mem_wdata
);

  dstate_e             st_q   [LINES];
  logic [NODES-1:0]    pres_q [LINES];
  logic [DATA_W-1:0]   mem_q  [LINES];

  assign rd_state = st_q[line];
  assign rd_pres  = pres_q[line];
  assign rd_data  = mem_q[line];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]   <= ST_UNC;
        pres_q[i] <= '0;
        mem_q[i]  <= DATA_W'(mem_seed(unsigned'(i)));
      end
    end else begin
      if (ent_we) begin
        st_q[line]   <= wr_state;
        pres_q[line] <= wr_pres;
      end
      if (mem_we) mem_q[line] <= mem_wdata;
    end
  end

endmodule

// File: rtl/dir_probe_seq.sv
module dir_probe_seq
  import dir_pkg::*;
#(
  parameter int NODES = 4,
  localparam int NID_W = $clog2(NODES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NODES-1:0] load_mask,
  input  prb_e             load_kind,
  output logic             prb_valid,
  output logic [NID_W-1:0] prb_dst,
  output prb_e             prb_kind
);

  logic [NODES-1:0] mask_q;
  prb_e             kind_q;

  function automatic logic [NID_W-1:0] lowest(input logic [NODES-1:0] m);
    logic [NID_W-1:0] r;
    r = '0;
    for (int i = NODES - 1; i >= 0; i--) if (m[i]) r = NID_W'(i);
    return r;
  endfunction

  assign prb_valid = |mask_q;
  assign prb_dst   = lowest(mask_q);
  assign prb_kind  = kind_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      kind_q <= PRB_INV;
    end else if (load) begin
      mask_q <= load_mask;
      kind_q <= load_kind;
    end else if (prb_valid) begin
      mask_q <= mask_q & ~(NODES'(1) << prb_dst);
    end
  end

endmodule

// File: rtl/dir_ack_tracker.sv
module dir_ack_tracker #(
  parameter int NODES = 4,
  localparam int CNT_W = $clog2(NODES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             sent_inc,
  input  logic             ack_inc,
  output logic [CNT_W-1:0] sent_cnt,
  output logic [CNT_W-1:0] ack_cnt,
  output logic             balanced
);

  assign balanced = (sent_cnt == ack_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      sent_cnt <= '0;
      ack_cnt  <= '0;
    end else begin
      if (sent_inc) sent_cnt <= sent_cnt + CNT_W'(1);
      if (ack_inc)  ack_cnt  <= ack_cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int LINES  = 8,
  parameter int DATA_W = 16,
  localparam int NID_W  = $clog2(NODES),
  localparam int LINE_W = $clog2(LINES),
  localparam int CNT_W  = $clog2(NODES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [NID_W-1:0]  req_src,
  input  logic [LINE_W-1:0] req_line,
  input  logic [DATA_W-1:0] req_data,
  input  logic              cresp_valid,
  input  logic              cresp_kind,
  input  logic [NID_W-1:0]  cresp_src,
  input  logic [LINE_W-1:0] cresp_line,
  input  logic [DATA_W-1:0] cresp_data,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic [NID_W-1:0]  rsp_dst,
  output logic [LINE_W-1:0] rsp_line,
  output logic [DATA_W-1:0] rsp_data,
  output logic              prb_valid,
  output logic              prb_kind,
  output logic [NID_W-1:0]  prb_dst,
  output logic [LINE_W-1:0] prb_line
);

  // open transaction
  logic              busy_q;
  logic [LINE_W-1:0] b_line_q;
  logic [NID_W-1:0]  b_src_q;
  logic              b_write_q;
  logic              b_dirty_q;
  logic [NODES-1:0]  b_pres_q;
  logic [NODES-1:0]  b_tgt_q;
  logic [DATA_W-1:0] pend_q;

  // table interface
  logic [LINE_W-1:0] tbl_line;
  dstate_e           rd_state;
  logic [NODES-1:0]  rd_pres;
  logic [DATA_W-1:0] rd_data;
  logic              tbl_we;
  dstate_e           tbl_wstate;
  logic [NODES-1:0]  tbl_wpres;
  logic              mem_we;
  logic [DATA_W-1:0] mem_wdata;

  // named internal events
  logic              ev_start;
  logic              ev_finish;
  logic              ev_nack;
  logic              ack_ok;
  logic [NODES-1:0]  start_mask;
  prb_e              start_kind;
  logic              seq_valid;
  prb_e              seq_kind;
  logic [CNT_W-1:0]  sent_cnt;
  logic [CNT_W-1:0]  ack_cnt;
  logic              balanced;

  // next reply
  logic              rsp_set;
  rsp_e              rsp_k_n;
  logic [NID_W-1:0]  rsp_d_n;
  logic [LINE_W-1:0] rsp_l_n;
  logic [DATA_W-1:0] rsp_data_n;

  logic [NODES-1:0]  req_bit;
  logic [NODES-1:0]  others;
  prb_e              ack_expect;

  function automatic logic [NODES-1:0] node_bit(input logic [NID_W-1:0] n);
    return NODES'(1) << n;
  endfunction

  assign tbl_line   = busy_q ? b_line_q : req_line;
  assign req_bit    = node_bit(req_src);
  assign others     = rd_pres & ~req_bit;
  assign ack_expect = b_write_q ? PRB_INV : PRB_FETCH;
  assign ack_ok     = busy_q && cresp_valid && (cresp_line == b_line_q)
                    && (cresp_kind == ack_expect) && b_tgt_q[cresp_src];

  dir_table #(.NODES(NODES), .LINES(LINES), .DATA_W(DATA_W)) u_table (
    .clk(clk), .rst_n(rst_n), .line(tbl_line),
    .rd_state(rd_state), .rd_pres(rd_pres), .rd_data(rd_data),
    .ent_we(tbl_we), .wr_state(tbl_wstate), .wr_pres(tbl_wpres),
    .mem_we(mem_we), .mem_wdata(mem_wdata)
  );

  dir_probe_seq #(.NODES(NODES)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(ev_start), .load_mask(start_mask),
    .load_kind(start_kind), .prb_valid(seq_valid), .prb_dst(prb_dst),
    .prb_kind(seq_kind)
  );

  dir_ack_tracker #(.NODES(NODES)) u_acks (
    .clk(clk), .rst_n(rst_n), .clear(ev_start), .sent_inc(seq_valid),
    .ack_inc(ack_ok), .sent_cnt(sent_cnt), .ack_cnt(ack_cnt),
    .balanced(balanced)
  );

  assign prb_valid = seq_valid;
  assign prb_kind  = seq_kind;
  assign prb_line  = b_line_q;

  always_comb begin
    tbl_we     = 1'b0;
    tbl_wstate = ST_UNC;
    tbl_wpres  = '0;
    mem_we     = 1'b0;
    mem_wdata  = pend_q;
    ev_start   = 1'b0;
    ev_finish  = 1'b0;
    ev_nack    = 1'b0;
    start_mask = '0;
    start_kind = PRB_INV;
    rsp_set    = 1'b0;
    rsp_k_n    = RSP_NACK;
    rsp_d_n    = req_src;
    rsp_l_n    = req_line;
    rsp_data_n = '0;
    if (!busy_q) begin
      if (req_valid) begin
        case (req_kind)
          REQ_READ: begin
            if (rd_state == ST_DIRTY) begin
              ev_start   = 1'b1;
              start_mask = rd_pres;
              start_kind = PRB_FETCH;
            end else begin
              tbl_we     = 1'b1;
              tbl_wstate = ST_SHR;
              tbl_wpres  = rd_pres | req_bit;
              rsp_set    = 1'b1;
              rsp_k_n    = RSP_DATA;
              rsp_data_n = rd_data;
            end
          end
          REQ_WRITE: begin
            if (|others) begin
              ev_start   = 1'b1;
              start_mask = others;
              start_kind = PRB_INV;
            end else begin
              tbl_we     = 1'b1;
              tbl_wstate = ST_DIRTY;
              tbl_wpres  = req_bit;
              rsp_set    = 1'b1;
              rsp_k_n    = RSP_GRANT;
              rsp_data_n = rd_data;
            end
          end
          REQ_WB: begin
            rsp_set = 1'b1;
            rsp_k_n = RSP_WBACK;
            if (rd_state == ST_DIRTY && rd_pres == req_bit) begin
              tbl_we     = 1'b1;
              tbl_wstate = ST_UNC;
              tbl_wpres  = '0;
              mem_we     = 1'b1;
              mem_wdata  = req_data;
            end
          end
          default: ;
        endcase
      end
    end else if (req_valid) begin
      ev_nack = 1'b1;
      rsp_set = 1'b1;
      rsp_k_n = RSP_NACK;
    end else if (!seq_valid && balanced) begin
      ev_finish  = 1'b1;
      rsp_set    = 1'b1;
      rsp_d_n    = b_src_q;
      rsp_l_n    = b_line_q;
      rsp_data_n = b_dirty_q ? pend_q : rd_data;
      tbl_we     = 1'b1;
      mem_we     = b_dirty_q;
      if (b_write_q) begin
        rsp_k_n    = RSP_GRANT;
        tbl_wstate = ST_DIRTY;
        tbl_wpres  = node_bit(b_src_q);
      end else begin
        rsp_k_n    = RSP_DATA;
        tbl_wstate = ST_SHR;
        tbl_wpres  = b_pres_q | node_bit(b_src_q);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      b_line_q  <= '0;
      b_src_q   <= '0;
      b_write_q <= 1'b0;
      b_dirty_q <= 1'b0;
      b_pres_q  <= '0;
      b_tgt_q   <= '0;
      pend_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_kind  <= RSP_DATA;
      rsp_dst   <= '0;
      rsp_line  <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rsp_set;
      if (rsp_set) begin
        rsp_kind <= rsp_k_n;
        rsp_dst  <= rsp_d_n;
        rsp_line <= rsp_l_n;
        rsp_data <= rsp_data_n;
      end
      if (ev_start) begin
        busy_q    <= 1'b1;
        b_line_q  <= req_line;
        b_src_q   <= req_src;
        b_write_q <= (req_kind == REQ_WRITE);
        b_dirty_q <= (rd_state == ST_DIRTY);
        b_pres_q  <= rd_pres;
        b_tgt_q   <= start_mask;
      end else if (ev_finish) begin
        busy_q <= 1'b0;
      end
      if (ack_ok && b_dirty_q) pend_q <= cresp_data;
    end
  end

endmodule

// File: rtl/dir_home_chk.sv
module dir_home_chk #(
  parameter int NODES = 4,
  parameter int NID_W = 2,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             req_valid,
  input logic             prb_valid,
  input logic             prb_kind,
  input logic [NID_W-1:0] prb_dst,
  input logic [NID_W-1:0] b_src,
  input logic             rsp_valid,
  input logic [1:0]       rsp_kind,
  input logic             tbl_we,
  input logic [1:0]       tbl_wstate,
  input logic [NODES-1:0] tbl_wpres,
  input logic             ev_finish,
  input logic [CNT_W-1:0] sent_cnt,
  input logic [CNT_W-1:0] ack_cnt
);

  AST_PROBE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    prb_valid |-> busy); // R4

  AST_INV_SKIPS_REQUESTER: assert property (@(posedge clk) disable iff (!rst_n)
    (prb_valid && prb_kind == 1'b0) |-> (prb_dst != b_src)); // R4

  AST_GRANT_BALANCED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_finish |-> (sent_cnt == ack_cnt)); // R5

  AST_ACKS_NOT_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (ack_cnt <= sent_cnt)); // R5

  AST_DIRTY_SINGLE_HOLDER: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_we && tbl_wstate == 2'd2) |-> ($countones(tbl_wpres) == 1)); // R5

  AST_UNCACHED_NO_HOLDER: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_we && tbl_wstate == 2'd0) |-> (tbl_wpres == '0)); // R9

  AST_RETRY_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> (rsp_valid && rsp_kind == 2'd2)); // R8

endmodule

bind dir_home_ctrl dir_home_chk #(.NODES(NODES), .NID_W(NID_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_q), .req_valid(req_valid),
  .prb_valid(prb_valid), .prb_kind(prb_kind), .prb_dst(prb_dst),
  .b_src(b_src_q), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
  .tbl_we(tbl_we), .tbl_wstate(tbl_wstate), .tbl_wpres(tbl_wpres),
  .ev_finish(ev_finish), .sent_cnt(sent_cnt), .ack_cnt(ack_cnt)
);

// File: tb/tb_dir_home_ctrl.sv
module tb_dir_home_ctrl;
  localparam int NODES = 4;
  localparam int LINES = 8;
  localparam int DW    = 16;

  logic          clk, rst_n;
  logic          req_valid;
  logic [1:0]    req_kind;
  logic [1:0]    req_src;
  logic [2:0]    req_line;
  logic [DW-1:0] req_data;
  logic          cresp_valid, cresp_kind;
  logic [1:0]    cresp_src;
  logic [2:0]    cresp_line;
  logic [DW-1:0] cresp_data;
  logic          rsp_valid;
  logic [1:0]    rsp_kind, rsp_dst;
  logic [2:0]    rsp_line;
  logic [DW-1:0] rsp_data;
  logic          prb_valid, prb_kind;
  logic [1:0]    prb_dst;
  logic [2:0]    prb_line;

  dir_home_ctrl #(.NODES(NODES), .LINES(LINES), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_src(req_src), .req_line(req_line), .req_data(req_data),
    .cresp_valid(cresp_valid), .cresp_kind(cresp_kind), .cresp_src(cresp_src),
    .cresp_line(cresp_line), .cresp_data(cresp_data),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_dst(rsp_dst),
    .rsp_line(rsp_line), .rsp_data(rsp_data), .prb_valid(prb_valid),
    .prb_kind(prb_kind), .prb_dst(prb_dst), .prb_line(prb_line)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;

  // reference directory: 0 uncached, 1 shared, 2 dirty
  int          m_state [LINES];
  logic [3:0]  m_pres  [LINES];
  logic [15:0] m_mem   [LINES];
  logic [15:0] cval    [LINES];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input int kind, input int src, input int line,
                        input logic [15:0] wd, input bit intr, input int isrc,
                        input string tag);
    logic [3:0]  got;
    int          last;
    bit          done, nack_seen, intruded, pk_seen;
    logic        pk;
    logic [1:0]  r_kind, r_dst;
    logic [2:0]  r_line;
    logic [15:0] r_data;
    logic [3:0]  bitm, exp_mask;
    logic        exp_pk;
    logic [1:0]  exp_rk;
    logic [15:0] exp_data;
    got = '0; last = -1; done = 0; nack_seen = 0; intruded = 0; pk_seen = 0;
    pk = 1'b0; r_kind = '0; r_dst = '0; r_line = '0; r_data = '0;
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind[1:0]; req_src = src[1:0];
    req_line = line[2:0]; req_data = wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (int cyc = 0; cyc < 40 && !done; cyc++) begin
      if (cyc > 0) @(negedge clk);
      req_valid = 1'b0; cresp_valid = 1'b0;
      if (rsp_valid) begin
        if (rsp_kind == 2'd2 && intruded && !nack_seen) begin
          nack_seen = 1;
          chk({tag, " R8 retry dst"}, {30'd0, rsp_dst}, isrc);
        end else begin
          done = 1; r_kind = rsp_kind; r_dst = rsp_dst;
          r_line = rsp_line; r_data = rsp_data;
        end
      end
      if (prb_valid && !done) begin
        chk({tag, " R4 probe order"}, {31'd0, (int'(prb_dst) > last)}, 32'd1);
        chk({tag, " probe line"}, {29'd0, prb_line}, line);
        last = int'(prb_dst);
        got[prb_dst] = 1'b1;
        pk = prb_kind; pk_seen = 1;
        cresp_valid = 1'b1; cresp_src = prb_dst; cresp_line = line[2:0];
        cresp_kind = prb_kind; cresp_data = cval[line];
        if (intr && !intruded) begin
          req_valid = 1'b1; req_kind = 2'd0; req_src = isrc[1:0];
          req_line = line[2:0]; intruded = 1;
        end
      end
    end
    cresp_valid = 1'b0; req_valid = 1'b0;
    chk({tag, " reply seen"}, {31'd0, done}, 32'd1);

    bitm = 4'b0001 << src;
    exp_mask = '0; exp_pk = 1'b0; exp_rk = 2'd3; exp_data = '0;
    case (kind)
      0: begin
        exp_rk = 2'd0;
        if (m_state[line] == 2) begin
          exp_mask = m_pres[line]; exp_pk = 1'b1;
          m_mem[line] = cval[line];
        end
        exp_data = m_mem[line];
        m_state[line] = 1; m_pres[line] = m_pres[line] | bitm;
      end
      1: begin
        exp_rk = 2'd1;
        exp_mask = m_pres[line] & ~bitm;
        if (m_state[line] == 2 && exp_mask != 0) m_mem[line] = cval[line];
        exp_data = m_mem[line];
        m_state[line] = 2; m_pres[line] = bitm; cval[line] = wd;
      end
      default: begin
        exp_rk = 2'd3;
        if (m_state[line] == 2 && m_pres[line] == bitm) begin
          m_mem[line] = wd; m_state[line] = 0; m_pres[line] = '0;
        end
      end
    endcase
    chk({tag, " probe set"}, {28'd0, got}, {28'd0, exp_mask});
    if (pk_seen) chk({tag, " probe kind"}, {31'd0, pk}, {31'd0, exp_pk});
    chk({tag, " reply kind"}, {30'd0, r_kind}, {30'd0, exp_rk});
    chk({tag, " reply dst"}, {30'd0, r_dst}, src);
    chk({tag, " reply line"}, {29'd0, r_line}, line);
    if (exp_rk != 2'd3) chk({tag, " reply data"}, {16'd0, r_data}, {16'd0, exp_data});
    if (intr && exp_mask != 0) chk({tag, " R8 retry seen"}, {31'd0, nack_seen}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = '0; req_src = '0; req_line = '0;
    req_data = '0; cresp_valid = 1'b0; cresp_kind = 1'b0; cresp_src = '0;
    cresp_line = '0; cresp_data = '0;
    for (int i = 0; i < LINES; i++) begin
      m_state[i] = 0; m_pres[i] = '0;
      m_mem[i] = 16'((i * 257) ^ 32'h5A5A);
      cval[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset reply idle", {31'd0, rsp_valid}, 32'd0);
    chk("R1 reset probe idle", {31'd0, prb_valid}, 32'd0);

    for (int l = 0; l < LINES; l++) begin
      int a, b, c, d;
      a = l % 4; b = (l + 1) % 4; c = (l + 2) % 4; d = (l + 3) % 4;
      run_op(0, a, l, 16'h0, 0, 0, "R1 R2 first read");
      run_op(0, b, l, 16'h0, 0, 0, "R2 shared read b");
      run_op(0, c, l, 16'h0, 0, 0, "R2 shared read c");
      run_op(1, b, l, 16'h1000 + 16'(l), 1, d, "R4 R5 R8 write with sharers");
      run_op(1, b, l, 16'h2000 + 16'(l), 0, 0, "R6 owner rewrite");
      run_op(2, a, l, 16'hBAD0, 0, 0, "R10 stale write-back");
      run_op(0, c, l, 16'h0, 0, 0, "R3 R10 read of dirty");
      run_op(1, d, l, 16'h3000 + 16'(l), 0, 0, "R4 R5 write over two sharers");
      run_op(1, a, l, 16'h4000 + 16'(l), 0, 0, "R7 write over dirty owner");
      run_op(2, a, l, 16'h5000 + 16'(l), 0, 0, "R9 owner write-back");
      run_op(0, d, l, 16'h0, 0, 0, "R9 read after write-back");
      run_op(2, d, l, 16'h6000 + 16'(l), 0, 0, "R10 write-back from sharer");
      run_op(1, c, l, 16'h7000 + 16'(l), 0, 0, "R4 R5 write over one sharer");
      run_op(2, c, l, 16'h8000 + 16'(l), 0, 0, "R9 write-back to uncached");
      run_op(1, b, l, 16'h9000 + 16'(l), 0, 0, "R6 write to uncached");
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule